// File: doc/BRIEF.md
# Shared-Buffer Packet Switching Fabric

This block joins a handful of packet ports through one on-chip buffer RAM. Each port offers a stream of 32-bit words. A flag marks the last word of each packet. A per-packet destination bitmask arrives as a sideband and is sampled with the first word. Arriving words wait in a small per-port FIFO. An ingress scheduler serves these FIFOs in turn and copies whole packets into the buffer RAM. The RAM is split into one circular region per source port. The destination mask is stored as a header word in front of each packet.

A forwarding scheduler takes turns between the regions that hold at least one complete packet. It pops exactly one packet from the chosen region and then picks again. Every word read from the RAM is presented to all egress exit queues at once. Only the queues whose bits are set in that packet's mask receive a write enable.

The exit queues sit outside the block and report back through a full flag each. A packet waits while any queue in its own mask is full. A packet that could not fit in its source region at its first word is discarded whole, and a per-port counter records the loss.

Top module: `sfab_switch`

## Requirements
- R1: After reset, every `in_ready` bit is 1, `eq_wr_en` is 0 and every drop counter reads 0.
- R2: A word is taken from port p when `in_valid[p]` and `in_ready[p]` are both high at a clock edge. When all ports send at once, the ingress scheduler serves the port FIFOs in turn, and every admitted packet of every port is delivered.
- R3: For each source, the packets reach each egress queue in the order they were sent. The words of one packet are written to a queue back to back, with no word of another packet between them.
- R4: Right after reset, the forwarding scheduler gives region 0 first priority and then rotates through the regions in increasing order, skipping regions with no complete packet. If regions 0, 1 and 2 each hold two packets, the first words leave in source order 0, 1, 2, 0, 1, 2.
- R5: Bit i of the sideband mask `in_dest[p*NP+i]` selects egress i. `eq_wr_en[i]` is set for a word only if bit i of that packet's mask is set. A packet with an all-zero mask is removed with no writes and does not hold up later packets.
- R6: `eq_wr_en[i]` is never high in the cycle after an edge at which `eq_full[i]` was high. A packet waits while any queue in its mask is full. A full queue outside its mask does not delay it.
- R7: Each region holds RDEPTH words, including one header word per packet. A packet is admitted only if its region has at least MAXW+1 free words when the packet starts. Otherwise it is dropped whole, `drop_count[p*CW +: CW]` rises by one, and none of its words appear at any queue.
- R8: Data words (at most MAXW per packet) leave on `eq_data` unchanged. `eq_last` is high together with the last word of each packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NP | Word offered, one bit per ingress port |
| in_last | input | NP | Offered word ends its packet |
| in_data | input | NP*DW | Ingress words, port p at bits p*DW +: DW |
| in_dest | input | NP*NP | Destination mask per port, sampled with the first word |
| in_ready | output | NP | Ingress FIFO of the port can take a word |
| eq_full | input | NP | Exit queue i cannot take a word |
| eq_wr_en | output | NP | Write enable per exit queue |
| eq_data | output | DW | Word broadcast to all exit queues |
| eq_last | output | 1 | Broadcast word ends its packet |
| drop_count | output | NP*CW | Dropped-packet counter per source port |

## Verification
The first pattern is a single packet with a two-bit mask, followed by a broadcast and a packet with an empty mask. Together these separate correct write gating from stray or missing enables. All four ports are then loaded at the same time with packets of different lengths. This exposes interleaving inside a region or at an exit queue, and it also exposes a port that is never served. In a further run, one queue is held full. Packets whose masks leave that queue out must keep flowing, and a packet that names it must stop. A run that starts from reset with one queue blocked fixes the exact rotation order. A long burst from one port into a blocked queue fills its region to the point where exactly one packet must be dropped and counted.

// File: rtl/sfab_pkg.sv
package sfab_pkg;
  typedef enum logic [1:0] {IN_IDLE, IN_COPY, IN_DISCARD} in_state_t;
  typedef enum logic [1:0] {FW_IDLE, FW_HEAD, FW_ISSUE, FW_GAP} fw_state_t;
endpackage

// File: rtl/sfab_fifo.sv
module sfab_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign empty   = (wp == rp);
  assign rd_data = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en && !full) wp <= wp + 1'b1;
      if (rd_en && !empty) rp <= rp + 1'b1;
    end
  end

  AST_FIFO_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty); // R2
endmodule

// File: rtl/sfab_buffer.sv
module sfab_buffer #(
  parameter int W     = 33,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfab_ingress.sv
module sfab_ingress
  import sfab_pkg::*;
#(
  parameter int NP     = 4,
  parameter int DW     = 32,
  parameter int RDEPTH = 64,
  parameter int MAXW   = 16,
  parameter int CW     = 8,
  localparam int NW    = $clog2(NP),
  localparam int RAW   = $clog2(RDEPTH),
  localparam int PW    = RAW + 1,
  localparam int EW    = DW + 1 + NP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NP-1:0]     q_empty,
  input  logic [NP*EW-1:0]  q_data,
  output logic [NP-1:0]     q_pop,
  input  logic [NP*PW-1:0]  head,
  output logic              ram_we,
  output logic [NW+RAW-1:0] ram_waddr,
  output logic [DW:0]       ram_wdata,
  output logic [NP-1:0]     commit,
  output logic [NP*CW-1:0]  drop_count
);
  in_state_t     state;
  logic [NW-1:0] cur, last_gnt, pick;
  logic          found, room, cur_ready, cur_last;
  logic [PW-1:0] wptr, pick_head, cur_head;
  logic [PW-1:0] tail [NP];
  logic [CW-1:0] drops [NP];
  logic [DW-1:0] cur_word;
  logic [NP-1:0] pick_dest;

  // rotating priority, starting after the port served last
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NP; k++) begin
      if (!found && !q_empty[(int'(last_gnt) + k) % NP]) begin
        found = 1'b1;
        pick  = NW'((int'(last_gnt) + k) % NP);
      end
    end
  end

  assign pick_dest = q_data[int'(pick)*EW + DW +: NP];
  assign pick_head = head[int'(pick)*PW +: PW];
  assign cur_head  = head[int'(cur)*PW +: PW];
  assign room      = (PW'(RDEPTH) - (tail[pick] - pick_head)) >= PW'(MAXW + 1);
  assign cur_ready = !q_empty[cur];
  assign cur_last  = q_data[int'(cur)*EW + EW - 1];
  assign cur_word  = q_data[int'(cur)*EW +: DW];

  always_comb begin
    q_pop     = '0;
    commit    = '0;
    ram_we    = 1'b0;
    ram_waddr = {cur, wptr[RAW-1:0]};
    ram_wdata = {cur_last, cur_word};
    case (state)
      IN_IDLE: begin
        ram_we    = found && room;
        ram_waddr = {pick, tail[pick][RAW-1:0]};
        ram_wdata = {1'b0, DW'(pick_dest)};
      end
      IN_COPY: begin
        ram_we      = cur_ready;
        q_pop[cur]  = cur_ready;
        commit[cur] = cur_ready && cur_last;
      end
      default: q_pop[cur] = cur_ready;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= IN_IDLE;
      cur      <= '0;
      last_gnt <= NW'(NP - 1);
      wptr     <= '0;
      for (int i = 0; i < NP; i++) begin
        tail[i]  <= '0;
        drops[i] <= '0;
      end
    end else begin
      case (state)
        IN_IDLE: if (found) begin
          cur      <= pick;
          last_gnt <= pick;
          if (room) begin
            wptr  <= tail[pick] + PW'(1);
            state <= IN_COPY;
          end else begin
            drops[pick] <= drops[pick] + CW'(1);
            state       <= IN_DISCARD;
          end
        end
        IN_COPY: if (cur_ready) begin
          wptr <= wptr + PW'(1);
          if (cur_last) begin
            tail[cur] <= wptr + PW'(1);
            state     <= IN_IDLE;
          end
        end
        default: if (cur_ready && cur_last) state <= IN_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_drop
    assign drop_count[g*CW +: CW] = drops[g];
  end

  AST_REGION_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
    (state == IN_COPY && cur_ready) |-> (PW'(wptr - cur_head) < PW'(RDEPTH))); // R7
endmodule

// File: rtl/sfab_forward.sv
module sfab_forward
  import sfab_pkg::*;
#(
  parameter int NP     = 4,
  parameter int DW     = 32,
  parameter int RDEPTH = 64,
  localparam int NW    = $clog2(NP),
  localparam int RAW   = $clog2(RDEPTH),
  localparam int PW    = RAW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NP-1:0]     pkt_avail,
  output logic              rd_en,
  output logic [NW+RAW-1:0] rd_addr,
  input  logic [DW:0]       rd_data,
  output logic [NP*PW-1:0]  head,
  output logic [NP-1:0]     done,
  input  logic [NP-1:0]     eq_full,
  output logic [NP-1:0]     eq_wr_en,
  output logic [DW-1:0]     eq_data,
  output logic              eq_last
);
  fw_state_t     state;
  logic [NW-1:0] cur, last_gnt, pick;
  logic          found, stall;
  logic [NP-1:0] mask;
  logic [PW-1:0] hd [NP];

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NP; k++) begin
      if (!found && pkt_avail[(int'(last_gnt) + k) % NP]) begin
        found = 1'b1;
        pick  = NW'((int'(last_gnt) + k) % NP);
      end
    end
  end

  assign stall = |(mask & eq_full);

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = {cur, hd[cur][RAW-1:0]};
    done    = '0;
    case (state)
      FW_IDLE: begin
        rd_en   = found;
        rd_addr = {pick, hd[pick][RAW-1:0]};
      end
      FW_ISSUE: rd_en = !stall;
      FW_GAP:   done[cur] = rd_data[DW];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FW_IDLE;
      cur      <= '0;
      last_gnt <= NW'(NP - 1);
      mask     <= '0;
      eq_wr_en <= '0;
      for (int i = 0; i < NP; i++) hd[i] <= '0;
    end else begin
      eq_wr_en <= '0;
      case (state)
        FW_IDLE: if (found) begin
          cur      <= pick;
          last_gnt <= pick;
          hd[pick] <= hd[pick] + PW'(1);
          state    <= FW_HEAD;
        end
        FW_HEAD: begin
          mask  <= rd_data[NP-1:0];
          state <= FW_ISSUE;
        end
        FW_ISSUE: if (!stall) begin
          hd[cur]  <= hd[cur] + PW'(1);
          eq_wr_en <= mask;
          state    <= FW_GAP;
        end
        default: state <= rd_data[DW] ? FW_IDLE : FW_ISSUE;
      endcase
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_head
    assign head[g*PW +: PW] = hd[g];
  end

  assign eq_data = rd_data[DW-1:0];
  assign eq_last = rd_data[DW];

  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
    (|eq_wr_en) |-> ((eq_wr_en & $past(eq_full)) == '0)); // R6
endmodule

// File: rtl/sfab_switch.sv
module sfab_switch #(
  parameter int NP     = 4,
  parameter int DW     = 32,
  parameter int FDEPTH = 8,
  parameter int RDEPTH = 64,
  parameter int MAXW   = 16,
  parameter int CW     = 8,
  localparam int NW    = $clog2(NP),
  localparam int RAW   = $clog2(RDEPTH),
  localparam int PW    = RAW + 1,
  localparam int EW    = DW + 1 + NP,
  localparam int KW    = $clog2(RDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    in_valid,
  input  logic [NP-1:0]    in_last,
  input  logic [NP*DW-1:0] in_data,
  input  logic [NP*NP-1:0] in_dest,
  output logic [NP-1:0]    in_ready,
  input  logic [NP-1:0]    eq_full,
  output logic [NP-1:0]    eq_wr_en,
  output logic [DW-1:0]    eq_data,
  output logic             eq_last,
  output logic [NP*CW-1:0] drop_count
);
  logic [NP-1:0]     q_full, q_empty, q_pop, commit, fw_done, pkt_avail;
  logic [NP*EW-1:0]  q_data;
  logic [NP*PW-1:0]  head;
  logic              ram_we, ram_re;
  logic [NW+RAW-1:0] ram_waddr, ram_raddr;
  logic [DW:0]       ram_wdata, ram_rdata;
  logic [KW-1:0]     pkt_cnt [NP];

  for (genvar g = 0; g < NP; g++) begin : g_port
    sfab_fifo #(.W(EW), .DEPTH(FDEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (in_valid[g]),
      .wr_data ({in_last[g], in_dest[g*NP +: NP], in_data[g*DW +: DW]}),
      .full    (q_full[g]),
      .rd_en   (q_pop[g]),
      .rd_data (q_data[g*EW +: EW]),
      .empty   (q_empty[g])
    );

    // complete packets held per region
    always_ff @(posedge clk) begin
      if (rst) pkt_cnt[g] <= '0;
      else     pkt_cnt[g] <= pkt_cnt[g] + KW'(commit[g]) - KW'(fw_done[g]);
    end
    assign pkt_avail[g] = (pkt_cnt[g] != '0);
  end

  assign in_ready = ~q_full;

  sfab_ingress #(.NP(NP), .DW(DW), .RDEPTH(RDEPTH), .MAXW(MAXW), .CW(CW)) u_ingress (
    .clk        (clk),
    .rst        (rst),
    .q_empty    (q_empty),
    .q_data     (q_data),
    .q_pop      (q_pop),
    .head       (head),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata),
    .commit     (commit),
    .drop_count (drop_count)
  );

  sfab_buffer #(.W(DW + 1), .DEPTH(NP * RDEPTH)) u_buffer (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  sfab_forward #(.NP(NP), .DW(DW), .RDEPTH(RDEPTH)) u_forward (
    .clk       (clk),
    .rst       (rst),
    .pkt_avail (pkt_avail),
    .rd_en     (ram_re),
    .rd_addr   (ram_raddr),
    .rd_data   (ram_rdata),
    .head      (head),
    .done      (fw_done),
    .eq_full   (eq_full),
    .eq_wr_en  (eq_wr_en),
    .eq_data   (eq_data),
    .eq_last   (eq_last)
  );

  AST_DONE_NEEDS_PKT: assert property (@(posedge clk) disable iff (rst)
    (|fw_done) |-> ((fw_done & ~pkt_avail) == '0)); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (eq_wr_en == '0)); // R1
endmodule

// File: tb/sfab_switch_test.sv
module sfab_switch_test;
  localparam int NP = 4, DW = 32, CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             vld [NP];
  logic             lst [NP];
  logic [DW-1:0]    dat [NP];
  logic [NP-1:0]    dst [NP];
  logic [NP-1:0]    in_valid, in_last, in_ready;
  logic [NP*DW-1:0] in_data;
  logic [NP*NP-1:0] in_dest;
  logic [NP-1:0]    eq_full = '0, eq_wr_en, full_p;
  logic [DW-1:0]    eq_data;
  logic             eq_last;
  logic [NP*CW-1:0] drop_count;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_valid[i]            = vld[i];
      in_last[i]             = lst[i];
      in_data[i*DW +: DW]    = dat[i];
      in_dest[i*NP +: NP]    = dst[i];
    end
  end

  sfab_switch uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last), .in_data(in_data),
    .in_dest(in_dest), .in_ready(in_ready), .eq_full(eq_full), .eq_wr_en(eq_wr_en),
    .eq_data(eq_data), .eq_last(eq_last), .drop_count(drop_count)
  );

  // reference model: expected {last,data} per (egress, source)
  logic [DW:0] expq [NP][NP][$];
  int cur_src [NP];
  int order_log [$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pending();
    int s = 0;
    for (int e = 0; e < NP; e++)
      for (int p = 0; p < NP; p++) s += expq[e][p].size();
    return s;
  endfunction

  always @(posedge clk) full_p <= eq_full;

  always @(negedge clk) begin
    if (!rst) begin
      for (int e = 0; e < NP; e++) begin
        if (eq_wr_en[e]) begin
          int s;
          s = int'(eq_data[31:24]);
          check(!full_p[e], "R6 write to full queue", 1, 0);
          if (cur_src[e] < 0 && e == 0) order_log.push_back(s);
          check(cur_src[e] < 0 || cur_src[e] == s, "R3 interleaved packet", s, cur_src[e]);
          if (s >= NP || expq[e][s].size() == 0) begin
            check(0, "R5 unexpected write", s, -1);
          end else begin
            logic [DW:0] x;
            x = expq[e][s].pop_front();
            check({eq_last, eq_data} == x, "R8 word", {eq_last, eq_data}, x);
          end
          cur_src[e] = eq_last ? -1 : s;
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int e = 0; e < NP; e++) cur_src[e] = -1;
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input int p, input int mask, input int len, input int id, input bit keep);
    for (int w = 0; w < len; w++) begin
      @(negedge clk);
      vld[p] = 1'b1;
      lst[p] = (w == len - 1);
      dat[p] = {8'(p), 8'(id), 16'(w)};
      dst[p] = NP'(mask);
      if (keep)
        for (int e = 0; e < NP; e++)
          if (mask[e]) expq[e][p].push_back({lst[p], dat[p]});
      while (!in_ready[p]) @(negedge clk);
    end
    @(negedge clk);
    vld[p] = 1'b0;
    lst[p] = 1'b0;
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (pending() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(pending() == 0, req, pending(), 0);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      vld[i] = 1'b0; lst[i] = 1'b0; dat[i] = '0; dst[i] = '0; cur_src[i] = -1;
    end
    do_reset();
    // R1 reset state
    check(in_ready == '1, "R1 in_ready", in_ready, 4'hF);
    check(eq_wr_en == '0, "R1 eq_wr_en", eq_wr_en, 0);
    check(drop_count == '0, "R1 drop_count", drop_count, 0);

    // R5/R8 single, broadcast, empty mask
    send_pkt(0, 4'b0110, 3, 1, 1);
    drain("R5 two-bit mask delivered");
    send_pkt(2, 4'b1111, 5, 2, 1);
    send_pkt(1, 4'b0000, 4, 3, 1);
    send_pkt(1, 4'b0001, 2, 4, 1);
    drain("R5 broadcast and empty mask");

    // R2/R3 all ports at once
    fork
      begin send_pkt(0, 4'b0011, 4, 10, 1); send_pkt(0, 4'b1000, 7, 11, 1); send_pkt(0, 4'b1111, 2, 12, 1); end
      begin send_pkt(1, 4'b1001, 6, 20, 1); send_pkt(1, 4'b0100, 1, 21, 1); send_pkt(1, 4'b0011, 9, 22, 1); end
      begin send_pkt(2, 4'b0101, 3, 30, 1); send_pkt(2, 4'b1110, 8, 31, 1); send_pkt(2, 4'b0001, 5, 32, 1); end
      begin send_pkt(3, 4'b1111, 16, 40, 1); send_pkt(3, 4'b0010, 2, 41, 1); send_pkt(3, 4'b1100, 4, 42, 1); end
    join
    drain("R2 all ports delivered under load");

    // R6 outside-set full does not stall; in-set full does
    eq_full = 4'b1000;
    send_pkt(0, 4'b0011, 3, 50, 1);
    send_pkt(0, 4'b0011, 5, 51, 1);
    wait_cyc(150);
    check(expq[0][0].size() + expq[1][0].size() == 0, "R6 not stalled by outside queue",
          expq[0][0].size() + expq[1][0].size(), 0);
    send_pkt(1, 4'b1000, 3, 52, 1);
    wait_cyc(100);
    check(expq[3][1].size() == 3, "R6 stalled on full queue", expq[3][1].size(), 3);
    eq_full = 4'b0000;
    drain("R6 resumes after release");

    // R4 rotation order from reset
    do_reset();
    order_log.delete();
    eq_full = 4'b0001;
    fork
      begin send_pkt(0, 4'b0001, 2, 60, 1); send_pkt(0, 4'b0001, 2, 61, 1); end
      begin send_pkt(1, 4'b0001, 2, 62, 1); send_pkt(1, 4'b0001, 2, 63, 1); end
      begin send_pkt(2, 4'b0001, 2, 64, 1); send_pkt(2, 4'b0001, 2, 65, 1); end
    join
    wait_cyc(100);
    eq_full = 4'b0000;
    drain("R4 rotation packets delivered");
    check(order_log.size() == 6, "R4 packet count", order_log.size(), 6);
    for (int i = 0; i < 6; i++)
      if (i < order_log.size()) check(order_log[i] == i % 3, "R4 source order", order_log[i], i % 3);

    // R7 drop when region lacks room (7 fit, 8th dropped)
    eq_full = 4'b0010;
    for (int k = 0; k < 8; k++) send_pkt(3, 4'b0010, 7, 70 + k, k < 7);
    wait_cyc(30);
    check(drop_count[3*CW +: CW] == 1, "R7 drop count port 3", drop_count[3*CW +: CW], 1);
    check(drop_count[0 +: 3*CW] == 0, "R7 other ports no drops", drop_count[0 +: 3*CW], 0);
    eq_full = 4'b0000;
    drain("R7 admitted packets delivered");
    send_pkt(3, 4'b0100, 3, 90, 1);
    drain("R7 port recovers after drop");
    check(drop_count[3*CW +: CW] == 1, "R7 count unchanged", drop_count[3*CW +: CW], 1);

    wait_cyc(10);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule